// File: doc/BRIEF.md
# Execution Priority Masking Unit

This block sits beside an instruction-retire stage and decides, at every instruction boundary, whether a pending asynchronous exception may preempt the instruction stream. It holds three mask registers: a global disable bit, a fault-level mask bit and a base-priority threshold. It combines them with the priority of the handler that is running to form the current execution level. Pending exceptions, and a separate non-maskable request, are compared against that level. The winning exception is reported together with the address at which execution would resume.

Priorities are numbers in which a smaller value is more urgent. Mask registers change only through write requests that accompany a retiring instruction. The parameter `DELAYED_BOOST` picks between two behaviours for a base-priority write that raises priority. With the value 0 it guards the boundary right after the write. With the value 1 that one boundary is still judged against the old level, and every later boundary sees the new one.

Top module: `exec_prio_mask`

## Requirements
- R1: While `rst_n` is low and after its release, `take_o` is 0, all three mask registers read as cleared (no masking), and nothing is taken until an instruction retires.
- R2: An exception is only taken if its priority value is strictly smaller than the execution level. In thread mode (`handler_active`=0) every configurable priority qualifies. With `handler_active`=1 the level is `handler_prio`, so an equal or larger value waits.
- R3: A nonzero base threshold B blocks every configurable exception with priority value >= B, and a value below B passes. A threshold of 0 masks nothing.
- R4: With `DELAYED_BOOST`=0, a base write that raises priority already governs the boundary right after the write. No exception at or below the new level is taken there.
- R5: With `DELAYED_BOOST`=1, the boundary right after a raising base write is judged against the old level. An exception taken there reports `ret_addr` equal to the `retire_next_pc` of the write.
- R6: With `DELAYED_BOOST`=1, from the boundary after the instruction that follows the raising write onward, the new level is enforced.
- R7: Writes to the global disable (`wr_sel`=0, bit 0 of `wr_data`) and to the fault mask (`wr_sel`=1, bit 0) govern the boundary right after the write in both modes. Either bit set blocks every configurable exception, so a delayed base boost is then invisible.
- R8: The raise-only base write (`wr_sel`=3) updates the threshold only when the new value is nonzero and either the threshold is 0 or the new value is smaller; otherwise the threshold keeps its value. The plain base write is `wr_sel`=2.
- R9: A base write that lowers priority (a larger value, or 0) governs the boundary right after the write in both modes.
- R10: Among eligible pending exceptions the smallest priority value wins, and ties go to the lowest exception number. An eligible non-maskable request beats all of them.
- R11: A decision is made only in a cycle with `retire_valid`=1. `take_o` pulses one cycle later, together with `take_id` and `ret_addr` equal to that cycle's `retire_next_pc`.
- R12: The non-maskable request is reported as `take_id` = NEXC. Neither mask bit blocks it, and it is blocked only while `in_nmi`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_valid | input | 1 | An instruction retires this cycle (a boundary follows it) |
| retire_next_pc | input | AW | Address of the instruction after the retiring one |
| wr_en | input | 1 | The retiring instruction writes a mask register |
| wr_sel | input | 2 | 0 disable bit, 1 fault mask bit, 2 base threshold, 3 raise-only base |
| wr_data | input | PW | Write value (bit 0 for the single-bit masks) |
| handler_active | input | 1 | A configurable-priority handler is running |
| handler_prio | input | PW | Priority of the running handler |
| in_nmi | input | 1 | The non-maskable handler is running |
| nmi_pend | input | 1 | Non-maskable request pending |
| exc_pend | input | NEXC | Pending configurable exceptions, one bit each |
| exc_prio | input | NEXC*PW | Priority of exception i in bits i*PW +: PW |
| take_o | output | 1 | Preemption granted at the last boundary |
| take_id | output | IDW | Number of the granted exception (NEXC for the non-maskable one) |
| ret_addr | output | AW | Resume address of the preempted stream |

## Verification
A decision belongs to the cycle in which `retire_valid` is high, including the effect of a write retiring in that same cycle. Its result appears on `take_o`, `take_id` and `ret_addr` after the next rising edge. The driver applies each instruction at a falling edge and files the expected grant once the following rising edge has passed. The monitor compares it at the next falling edge, so each result is checked exactly one cycle after its stimulus and never at an edge. Two instances, one per boost mode, see identical stimulus, and each carries its own expectation. This is how the single boundary where the modes part is observed.

// File: rtl/epm_pkg.sv
package epm_pkg;

  typedef enum logic [1:0] {
    SEL_DIS  = 2'd0,
    SEL_FLT  = 2'd1,
    SEL_BASE = 2'd2,
    SEL_BMAX = 2'd3
  } mask_sel_e;

endpackage

// File: rtl/epm_mask_file.sv
// Mask registers plus the view that governs the boundary after the
// retiring instruction.
module epm_mask_file
  import epm_pkg::*;
#(
  parameter int PW            = 4,
  parameter bit DELAYED_BOOST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  mask_sel_e     wr_sel,
  input  logic [PW-1:0] wr_data,
  output logic          dis_q,
  output logic          flt_q,
  output logic [PW-1:0] base_q,
  output logic          dis_v,
  output logic          flt_v,
  output logic [PW-1:0] base_v
);

  logic          dis_nx;
  logic          flt_nx;
  logic [PW-1:0] base_nx;
  logic          boost;

  always_comb begin
    dis_nx  = dis_q;
    flt_nx  = flt_q;
    base_nx = base_q;
    if (wr_fire) begin
      unique case (wr_sel)
        SEL_DIS:  dis_nx  = wr_data[0];
        SEL_FLT:  flt_nx  = wr_data[0];
        SEL_BASE: base_nx = wr_data;
        SEL_BMAX: begin
          if ((wr_data != '0) && ((base_q == '0) || (wr_data < base_q)))
            base_nx = wr_data;
        end
        default: ;
      endcase
    end
  end

  // A write that makes the threshold stricter.
  assign boost = (base_nx != '0) && ((base_q == '0) || (base_nx < base_q));

  assign dis_v = dis_nx;
  assign flt_v = flt_nx;

  generate
    if (DELAYED_BOOST) begin : g_late
      assign base_v = boost ? base_q : base_nx;
    end else begin : g_early
      assign base_v = base_nx;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= 1'b0;
      flt_q  <= 1'b0;
      base_q <= '0;
    end else if (wr_fire) begin
      dis_q  <= dis_nx;
      flt_q  <= flt_nx;
      base_q <= base_nx;
    end
  end

endmodule

// File: rtl/epm_level_calc.sv
// Execution level: 0 = NMI, 1 = fault mask, 2+p = priority p,
// (1<<PW)+2 = thread with nothing masked.
module epm_level_calc #(
  parameter int PW = 4,
  localparam int LW = PW + 2
) (
  input  logic          handler_active,
  input  logic [PW-1:0] handler_prio,
  input  logic          in_nmi,
  input  logic          dis,
  input  logic          flt,
  input  logic [PW-1:0] base,
  output logic [LW-1:0] lvl
);

  localparam logic [LW-1:0] LVL_THREAD = LW'((1 << PW) + 2);
  localparam logic [LW-1:0] OFS        = LW'(2);
  localparam logic [LW-1:0] LVL_DIS    = LW'(2);
  localparam logic [LW-1:0] LVL_FLT    = LW'(1);

  logic [LW-1:0] base_lvl;
  logic [LW-1:0] hnd_lvl;

  assign base_lvl = {2'b00, base} + OFS;
  assign hnd_lvl  = {2'b00, handler_prio} + OFS;

  always_comb begin
    lvl = LVL_THREAD;
    if (handler_active)                     lvl = hnd_lvl;
    if ((base != '0) && (base_lvl < lvl))   lvl = base_lvl;
    if (dis && (LVL_DIS < lvl))             lvl = LVL_DIS;
    if (flt && (LVL_FLT < lvl))             lvl = LVL_FLT;
    if (in_nmi)                             lvl = '0;
  end

endmodule

// File: rtl/epm_pick.sv
// Selects the winning pending exception against the execution level.
module epm_pick #(
  parameter int NEXC = 8,
  parameter int PW   = 4,
  localparam int LW  = PW + 2,
  localparam int IDW = $clog2(NEXC + 1)
) (
  input  logic [LW-1:0]      lvl,
  input  logic [NEXC-1:0]    exc_pend,
  input  logic [NEXC*PW-1:0] exc_prio,
  input  logic               nmi_pend,
  output logic               hit,
  output logic [IDW-1:0]     id
);

  localparam logic [LW-1:0] OFS = LW'(2);

  logic [NEXC-1:0] elig;
  logic [PW-1:0]   pr [NEXC];

  generate
    for (genvar i = 0; i < NEXC; i++) begin : g_src
      assign pr[i]   = exc_prio[i*PW +: PW];
      assign elig[i] = exc_pend[i] && (({2'b00, pr[i]} + OFS) < lvl);
    end
  endgenerate

  logic [PW-1:0] best_pr;

  always_comb begin
    hit     = 1'b0;
    id      = '0;
    best_pr = '1;
    for (int i = 0; i < NEXC; i++) begin
      if (elig[i] && (!hit || (pr[i] < best_pr))) begin
        hit     = 1'b1;
        id      = IDW'(i);
        best_pr = pr[i];
      end
    end
    if (nmi_pend && (lvl != '0)) begin
      hit = 1'b1;
      id  = IDW'(NEXC);
    end
  end

endmodule

// File: rtl/exec_prio_mask.sv
module exec_prio_mask
  import epm_pkg::*;
#(
  parameter int NEXC          = 8,
  parameter int PW            = 4,
  parameter int AW            = 32,
  parameter bit DELAYED_BOOST = 1'b0,
  localparam int LW           = PW + 2,
  localparam int IDW          = $clog2(NEXC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retire_valid,
  input  logic [AW-1:0]      retire_next_pc,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [PW-1:0]      wr_data,
  input  logic               handler_active,
  input  logic [PW-1:0]      handler_prio,
  input  logic               in_nmi,
  input  logic               nmi_pend,
  input  logic [NEXC-1:0]    exc_pend,
  input  logic [NEXC*PW-1:0] exc_prio,
  output logic               take_o,
  output logic [IDW-1:0]     take_id,
  output logic [AW-1:0]      ret_addr
);

  logic          wr_fire;
  logic          dis_q, flt_q, dis_v, flt_v;
  logic [PW-1:0] base_q, base_v;
  logic [LW-1:0] lvl;
  logic          hit;
  logic [IDW-1:0] win_id;

  assign wr_fire = retire_valid && wr_en;

  epm_mask_file #(.PW(PW), .DELAYED_BOOST(DELAYED_BOOST)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_sel  (mask_sel_e'(wr_sel)),
    .wr_data (wr_data),
    .dis_q   (dis_q),
    .flt_q   (flt_q),
    .base_q  (base_q),
    .dis_v   (dis_v),
    .flt_v   (flt_v),
    .base_v  (base_v)
  );

  epm_level_calc #(.PW(PW)) u_lvl (
    .handler_active (handler_active),
    .handler_prio   (handler_prio),
    .in_nmi         (in_nmi),
    .dis            (dis_v),
    .flt            (flt_v),
    .base           (base_v),
    .lvl            (lvl)
  );

  epm_pick #(.NEXC(NEXC), .PW(PW)) u_pick (
    .lvl      (lvl),
    .exc_pend (exc_pend),
    .exc_prio (exc_prio),
    .nmi_pend (nmi_pend),
    .hit      (hit),
    .id       (win_id)
  );

  // Next-state for the grant outputs.
  logic           take_d;
  logic           cap_en;

  assign take_d = retire_valid && hit;
  assign cap_en = take_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o <= 1'b0;
    end else begin
      take_o <= take_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_id  <= '0;
      ret_addr <= '0;
    end else if (cap_en) begin
      take_id  <= win_id;
      ret_addr <= retire_next_pc;
    end
  end

  // Unused register copies kept visible to the checker.
  logic unused_q;
  assign unused_q = flt_q ^ dis_q;

endmodule

// File: rtl/epm_chk.sv
module epm_chk #(
  parameter int NEXC = 8,
  parameter int PW   = 4,
  parameter int IDW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            retire_valid,
  input logic            wr_en,
  input logic [1:0]      wr_sel,
  input logic [PW-1:0]   wr_data,
  input logic            nmi_pend,
  input logic [NEXC-1:0] exc_pend,
  input logic            take_o,
  input logic [IDW-1:0]  take_id,
  input logic            dis_v,
  input logic [PW-1:0]   base_q
);

  logic [NEXC-1:0] pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_d <= '0;
    else        pend_d <= exc_pend;
  end

  assert_grant_after_retire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(retire_valid));

  assert_disable_blocks_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && (take_id != IDW'(NEXC))) |-> !$past(dis_v));

  assert_raise_only_zero_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && wr_en && (wr_sel == 2'd3) && (wr_data == '0)) |=> (base_q == $past(base_q)));

  assert_nmi_grant_needs_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && (take_id == IDW'(NEXC))) |-> $past(nmi_pend));

  assert_winner_was_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && (take_id < IDW'(NEXC))) |-> pend_d[take_id]);

endmodule

bind exec_prio_mask epm_chk #(.NEXC(NEXC), .PW(PW), .IDW(IDW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .retire_valid (retire_valid),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .nmi_pend     (nmi_pend),
  .exc_pend     (exc_pend),
  .take_o       (take_o),
  .take_id      (take_id),
  .dis_v        (dis_v),
  .base_q       (base_q)
);

// File: tb/sim_exec_prio_mask.sv
`timescale 1ns/1ps
module sim_exec_prio_mask;

  localparam int NEXC = 8;
  localparam int PW   = 4;
  localparam int AW   = 32;
  localparam int IDW  = $clog2(NEXC + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_n;
  logic               rv, we, hact, innmi, nmi;
  logic [AW-1:0]      npc;
  logic [1:0]         sel;
  logic [PW-1:0]      wd, hprio;
  logic [NEXC-1:0]    pend;
  logic [PW-1:0]      pr [NEXC];
  logic [NEXC*PW-1:0] prio_flat;

  always_comb
    for (int i = 0; i < NEXC; i++) prio_flat[i*PW +: PW] = pr[i];

  logic           t0, t1;
  logic [IDW-1:0] id0, id1;
  logic [AW-1:0]  a0, a1;

  exec_prio_mask #(.NEXC(NEXC), .PW(PW), .AW(AW), .DELAYED_BOOST(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .retire_valid(rv), .retire_next_pc(npc),
    .wr_en(we), .wr_sel(sel), .wr_data(wd), .handler_active(hact),
    .handler_prio(hprio), .in_nmi(innmi), .nmi_pend(nmi), .exc_pend(pend),
    .exc_prio(prio_flat), .take_o(t0), .take_id(id0), .ret_addr(a0));

  exec_prio_mask #(.NEXC(NEXC), .PW(PW), .AW(AW), .DELAYED_BOOST(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .retire_valid(rv), .retire_next_pc(npc),
    .wr_en(we), .wr_sel(sel), .wr_data(wd), .handler_active(hact),
    .handler_prio(hprio), .in_nmi(innmi), .nmi_pend(nmi), .exc_pend(pend),
    .exc_prio(prio_flat), .take_o(t1), .take_id(id1), .ret_addr(a1));

  typedef struct {
    bit          t0;
    int          i0;
    bit          t1;
    int          i1;
    logic [31:0] a;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  exp_t e;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: compares the grant due one cycle after each instruction.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      cmp(e.tag, "u0 take", int'(t0), int'(e.t0));
      cmp(e.tag, "u1 take", int'(t1), int'(e.t1));
      if (e.t0 && t0) begin
        cmp(e.tag, "u0 id", int'(id0), e.i0);
        cmp(e.tag, "u0 addr", int'(a0), int'(e.a));
      end
      if (e.t1 && t1) begin
        cmp(e.tag, "u1 id", int'(id1), e.i1);
        cmp(e.tag, "u1 addr", int'(a1), int'(e.a));
      end
    end
  end

  logic [31:0] pc = 32'h100;

  // Driver: one instruction boundary per call.
  task automatic step(input bit r, input bit w, input logic [1:0] s, input logic [3:0] d,
                      input logic [7:0] pv, input bit nm,
                      input bit et0, input int ei0, input bit et1, input int ei1,
                      input string tag);
    exp_t x;
    @(negedge clk);
    pc   = pc + 4;
    rv   = r;  we = w;  sel = s;  wd = d;
    pend = pv; nmi = nm; npc = pc;
    @(posedge clk);
    #1;
    x.t0 = et0; x.i0 = ei0; x.t1 = et1; x.i1 = ei1; x.a = pc; x.tag = tag;
    sbq.push_back(x);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rv = 0; we = 0; sel = 0; wd = 0; hact = 0; hprio = 0;
    innmi = 0; nmi = 0; pend = 0; npc = 0;
    for (int i = 0; i < NEXC; i++) pr[i] = '0;
    repeat (3) @(negedge clk);
    cmp("R1", "u0 take in reset", int'(t0), 0);
    cmp("R1", "u1 take in reset", int'(t1), 0);
    @(negedge clk);
    rst_n = 1'b1;

    step(1,0,2'd0,4'd0,8'h00,0, 0,0,0,0, "R1 idle after reset");
    pr[3] = 4'd5;
    step(1,0,2'd0,4'd0,8'h08,0, 1,3,1,3, "R2 thread grant");
    step(0,0,2'd0,4'd0,8'h08,0, 0,0,0,0, "R11 no retire");
    hact = 1'b1; hprio = 4'd5;
    step(1,0,2'd0,4'd0,8'h08,0, 0,0,0,0, "R2 equal to handler");
    pr[2] = 4'd4;
    step(1,0,2'd0,4'd0,8'h04,0, 1,2,1,2, "R2 above handler");
    hact = 1'b0;

    // Raising base write: modes part at this boundary only.
    pr[3] = 4'd6;
    step(1,1,2'd2,4'd4,8'h08,0, 0,0,1,3, "R4 R5 base boost");
    step(1,0,2'd0,4'd0,8'h08,0, 0,0,0,0, "R6 window closed");
    pr[2] = 4'd3;
    step(1,0,2'd0,4'd0,8'h04,0, 1,2,1,2, "R3 below threshold");
    pr[3] = 4'd4;
    step(1,0,2'd0,4'd0,8'h08,0, 0,0,0,0, "R3 equal threshold");
    pr[3] = 4'd6;
    step(1,1,2'd2,4'd0,8'h08,0, 1,3,1,3, "R9 lower to zero");

    // Raise-only variant.
    step(1,1,2'd3,4'd0,8'h08,0, 1,3,1,3, "R8 zero ignored");
    step(1,1,2'd3,4'd5,8'h08,0, 0,0,1,3, "R8 R5 raise-only boost");
    step(1,0,2'd0,4'd0,8'h08,0, 0,0,0,0, "R6 raise-only enforced");
    step(1,1,2'd3,4'd7,8'h08,0, 0,0,0,0, "R8 larger ignored");
    step(1,1,2'd2,4'd7,8'h08,0, 1,3,1,3, "R9 plain lower");
    step(1,1,2'd2,4'd0,8'h00,0, 0,0,0,0, "R9 restore");

    // Global disable and fault mask.
    pr[0] = 4'd0;
    step(1,1,2'd0,4'd1,8'h01,0, 0,0,0,0, "R7 disable immediate");
    step(1,0,2'd0,4'd0,8'h00,1, 1,8,1,8, "R12 nmi under disable");
    step(1,1,2'd2,4'd4,8'h08,0, 0,0,0,0, "R7 boost hidden by disable");
    step(1,1,2'd0,4'd0,8'h08,0, 0,0,0,0, "R7 enable with base held");
    step(1,0,2'd0,4'd0,8'h04,0, 1,2,1,2, "R3 after enable");
    step(1,1,2'd2,4'd0,8'h00,0, 0,0,0,0, "R9 restore");
    step(1,1,2'd1,4'd1,8'h01,0, 0,0,0,0, "R7 fault mask");
    step(1,0,2'd0,4'd0,8'h00,1, 1,8,1,8, "R12 nmi under fault mask");
    step(1,1,2'd1,4'd0,8'h00,0, 0,0,0,0, "R7 fault clear");
    innmi = 1'b1;
    step(1,0,2'd0,4'd0,8'h00,1, 0,0,0,0, "R12 nmi blocked in nmi");
    innmi = 1'b0;

    // Arbitration.
    pr[1] = 4'd6; pr[4] = 4'd2; pr[6] = 4'd2;
    step(1,0,2'd0,4'd0,8'h52,0, 1,4,1,4, "R10 smallest value");
    pr[5] = 4'd7; pr[2] = 4'd7;
    step(1,0,2'd0,4'd0,8'h24,0, 1,2,1,2, "R10 tie lowest number");
    step(1,0,2'd0,4'd0,8'h01,1, 1,8,1,8, "R10 R12 nmi wins");
    step(0,0,2'd0,4'd0,8'h00,0, 0,0,0,0, "R11 quiet");
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule